// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port that carries nine data bits per frame. A small register interface sets it up and moves data. Writing the data register loads an eight-bit byte and begins a transmission. The ninth transmitted bit comes from a control bit, and its value is captured at the moment of that write. Reading the data register returns the last byte received. The ninth received bit is stored in a status bit. Two sticky flags mark the end of a transmission and the end of a reception. Software clears each flag with a write to the status register.

Bit timing comes from one of two sources. In fixed mode a divided system clock sets the bit period to 16, 32 or 64 system clocks. In variable mode the timing comes from external timer-overflow strobes. Transmit and receive each choose their own strobe, and 16 strobes make up one bit. The receiver takes 16 samples per bit and votes on the middle three. The transmit-done flag normally drives the serial interrupt. When two routing bits are both set, it drives a separate system-flag interrupt instead.

The transmit machine has three states. It moves from TX_IDLE to TX_ARM on a data write. It moves from TX_ARM to TX_SEND on the next bit-clock edge. It returns from TX_SEND to TX_IDLE after the stop bit. The receive machine also has three states. It moves from RX_IDLE to RX_START on a sampled falling edge while reception is enabled. It moves from RX_START to RX_DATA when the start bit is still low at mid-bit, and back to RX_IDLE when it is not (a false start). It returns from RX_DATA to RX_IDLE after the ninth data bit. Clearing the receive-enable bit forces RX_IDLE from any state.

Top module: `nine_bit_uart`

## Requirements
- R1: Each transmitted frame is 11 bits long, in this order: a 0 start bit, eight data bits with the least significant bit first, the ninth bit, and a 1 stop bit. txd stays at 1 whenever no frame is being sent.
- R2: The ninth transmitted bit is the value of control bit 1 at the moment the data register (address 0) is written. A later change of that control bit does not alter a frame already requested.
- R3: A data write while the transmitter is idle starts a frame within one bit period, at the next bit-clock edge. A data write while a frame is pending or in progress is ignored.
- R4: Status bit 0 (tx_done) is set when the ninth data bit has finished sending, which is the start of the stop bit. It is 0 while the ninth bit is still being sent.
- R5: A frame is received only while control bit 0 (rx_en) is 1. Reception begins on a 1-to-0 transition of rxd seen on a sampling tick. Each bit value is the majority of samples 7, 8 and 9 out of the 16 taken per bit. A start bit that is not low by that vote is discarded.
- R6: After the ninth data bit of a frame, status bit 1 (rx_done) is set. The received byte becomes readable at address 0, and the received ninth bit appears as status bit 2.
- R7: A frame that completes while rx_done is already 1 is dropped. The byte, the ninth bit and the flag all stay as they were.
- R8: In fixed mode (control bit 2 = 0), control bits 4:3 select the bit period: 0 gives 16 clocks, 1 gives 32 clocks, and 2 or 3 gives 64 clocks.
- R9: In variable mode (control bit 2 = 1), one bit lasts 16 strobes. Transmit counts t1_ovf when control bit 5 is 0 and t2_ovf when it is 1. Receive makes the same choice with control bit 6.
- R10: With both bits 0 and 1 of the routing register (address 3) set, tx_done drives sysflag_irq and not serial_irq. Otherwise tx_done drives serial_irq. rx_done always drives serial_irq.
- R11: After reset, txd is 1, both interrupts are 0, and all registers read 0, so the receiver is disabled.
- R12: Both flags stay set until software writes the status register (address 2). Write-data bit 0 sets or clears tx_done, and bit 1 sets or clears rx_done. A hardware set in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 control, 2 status, 3 routing |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Combinational read data |
| rxd | input | 1 | Serial input |
| t1_ovf | input | 1 | First timer-overflow strobe |
| t2_ovf | input | 1 | Second timer-overflow strobe |
| txd | output | 1 | Serial output |
| serial_irq | output | 1 | Serial interrupt request |
| sysflag_irq | output | 1 | System-flag interrupt request |

## Verification
The assertions assume that wr_addr and wr_data are stable whenever wr_en is high. They assume the overflow strobes last one clock each. They also assume the oversampling rate is a power of two, so that the sample counters wrap without an explicit limit. The bench changes every input only on the falling clock edge. It drives each overflow strobe high for a single clock at a fixed spacing of three or five clocks. It holds every received bit for a whole number of bit periods, and it shortens rxd only on purpose, in the false-start case.

// File: rtl/nbu_pkg.sv
package nbu_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_SEND} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_t;

    localparam logic [1:0] A_DATA  = 2'd0;
    localparam logic [1:0] A_CTRL  = 2'd1;
    localparam logic [1:0] A_FLAGS = 2'd2;
    localparam logic [1:0] A_ROUTE = 2'd3;
endpackage

// File: rtl/nbu_tick.sv
module nbu_tick #(
    parameter int PRE_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       var_mode,
    input  logic [1:0] div_sel,
    input  logic       tmr_sel,
    input  logic       t1_ovf,
    input  logic       t2_ovf,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic             fixed_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        unique case (div_sel)
            2'd0:    fixed_tick = 1'b1;
            2'd1:    fixed_tick = pre_q[0];
            default: fixed_tick = &pre_q;
        endcase
    end

    assign tick = var_mode ? (tmr_sel ? t2_ovf : t1_ovf) : fixed_tick;

    // R8: the slowest fixed divisor never gives two ticks back to back
    p_slow_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!var_mode && div_sel == 2'd2 && tick) |=> (!tick || var_mode || div_sel == 2'd0));
endmodule

// File: rtl/nbu_tx.sv
module nbu_tx
    import nbu_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          bit9,
    output logic          txd,
    output logic          done_pulse
);
    localparam int CW = $clog2(OS_RATE);
    localparam int FW = DW + 3;
    localparam int BW = $clog2(FW);

    tx_state_t       state_q, state_d;
    logic [CW-1:0]   div_q;
    logic [FW-1:0]   shreg_q;
    logic [BW-1:0]   bit_q;
    logic            bit_edge;
    logic            last_bit;

    assign bit_edge = tick && (div_q == CW'(OS_RATE - 1));
    assign last_bit = (bit_q == BW'(FW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else if (tick) div_q <= bit_edge ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start) state_d = TX_ARM;
            TX_ARM:  if (bit_edge) state_d = TX_SEND;
            TX_SEND: if (bit_edge && last_bit) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '1;
            bit_q   <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: if (start) shreg_q <= {1'b1, bit9, data, 1'b0};
                TX_ARM:  bit_q <= '0;
                TX_SEND: if (bit_edge) begin
                    shreg_q <= {1'b1, shreg_q[FW-1:1]};
                    bit_q   <= bit_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign txd        = (state_q == TX_SEND) ? shreg_q[0] : 1'b1;
    assign done_pulse = (state_q == TX_SEND) && bit_edge && (bit_q == BW'(DW + 1));

    // R3: the frame starts only on a bit-clock edge
    p_start_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND && $past(state_q) != TX_SEND) |-> $past(bit_edge));
    // R3: a write while busy leaves the loaded frame alone
    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_ARM && start && !bit_edge) |=> $stable(shreg_q));
    // R1: stop bit is a mark
    p_stop_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND && last_bit) |-> txd);
    // R4: the done pulse is a single cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
endmodule

// File: rtl/nbu_rx.sv
module nbu_rx
    import nbu_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx_en,
    input  logic          rxd,
    output logic          frame_pulse,
    output logic [DW-1:0] frame_data,
    output logic          frame_b9
);
    localparam int CW  = $clog2(OS_RATE);
    localparam int MID = OS_RATE / 2;
    localparam int NB  = DW + 1;
    localparam int BW  = $clog2(NB + 1);

    rx_state_t      state_q, state_d;
    logic           s1_q, s2_q, prev_q;
    logic [CW-1:0]  cnt_q, nxt;
    logic [1:0]     vote_q;
    logic [BW-1:0]  bit_q;
    logic [NB-1:0]  sh_q, word;
    logic           fall, decide, maj, last_bit;

    assign nxt      = cnt_q + 1'b1;
    assign fall     = tick && prev_q && !s2_q;
    assign decide   = tick && (nxt == CW'(MID + 1));
    assign maj      = (vote_q[0] & vote_q[1]) | (vote_q[0] & s2_q) | (vote_q[1] & s2_q);
    assign last_bit = (bit_q == BW'(NB - 1));
    assign word     = {maj, sh_q[NB-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
            if (tick) prev_q <= s2_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (rx_en && fall) state_d = RX_START;
            RX_START: if (!rx_en || (decide && maj)) state_d = RX_IDLE;
                      else if (decide) state_d = RX_DATA;
            RX_DATA:  if (!rx_en || (decide && last_bit)) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            vote_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
        end else if (state_q == RX_IDLE) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (tick) begin
            cnt_q <= nxt;
            if (nxt == CW'(MID - 1)) vote_q[0] <= s2_q;
            if (nxt == CW'(MID))     vote_q[1] <= s2_q;
            if (decide && state_q == RX_DATA) begin
                sh_q  <= word;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign frame_pulse = (state_q == RX_DATA) && rx_en && decide && last_bit;
    assign frame_data  = word[DW-1:0];
    assign frame_b9    = word[DW];

    // R5: disabling reception returns the machine to idle
    p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state_q == RX_IDLE);
    // R5: a frame starts only from an enabled idle receiver
    p_start_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && $past(state_q) == RX_IDLE) |-> $past(rx_en));
    // R6: a finished frame ends the reception
    p_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> state_q == RX_IDLE);
endmodule

// File: rtl/nine_bit_uart.sv
module nine_bit_uart
    import nbu_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          rxd,
    input  logic          t1_ovf,
    input  logic          t2_ovf,
    output logic          txd,
    output logic          serial_irq,
    output logic          sysflag_irq
);
    localparam int CTRL_W = 7;

    logic [CTRL_W-1:0] ctrl_q;
    logic [1:0]        route_q;
    logic              tx_done_q, rx_done_q, rx_b9_q;
    logic [DW-1:0]     rx_byte_q;
    logic              data_wr, flag_wr, routed;
    logic              tx_tick, rx_tick, tx_done_pulse;
    logic              frame_pulse, frame_b9;
    logic [DW-1:0]     frame_data;

    assign data_wr = wr_en && (wr_addr == A_DATA);
    assign flag_wr = wr_en && (wr_addr == A_FLAGS);

    nbu_tick u_tx_tick (
        .clk(clk), .rst_n(rst_n), .var_mode(ctrl_q[2]), .div_sel(ctrl_q[4:3]),
        .tmr_sel(ctrl_q[5]), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf), .tick(tx_tick)
    );

    nbu_tick u_rx_tick (
        .clk(clk), .rst_n(rst_n), .var_mode(ctrl_q[2]), .div_sel(ctrl_q[4:3]),
        .tmr_sel(ctrl_q[6]), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf), .tick(rx_tick)
    );

    nbu_tx #(.OS_RATE(OS_RATE), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick), .start(data_wr),
        .data(wr_data), .bit9(ctrl_q[1]), .txd(txd), .done_pulse(tx_done_pulse)
    );

    nbu_rx #(.OS_RATE(OS_RATE), .DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rx_en(ctrl_q[0]), .rxd(rxd),
        .frame_pulse(frame_pulse), .frame_data(frame_data), .frame_b9(frame_b9)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL)  ctrl_q  <= wr_data[CTRL_W-1:0];
            if (wr_addr == A_ROUTE) route_q <= wr_data[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_done_q <= 1'b0;
            rx_done_q <= 1'b0;
            rx_b9_q   <= 1'b0;
            rx_byte_q <= '0;
        end else begin
            if (flag_wr) begin
                tx_done_q <= wr_data[0];
                rx_done_q <= wr_data[1];
            end
            if (tx_done_pulse) tx_done_q <= 1'b1;
            if (frame_pulse && !rx_done_q) begin
                rx_done_q <= 1'b1;
                rx_byte_q <= frame_data;
                rx_b9_q   <= frame_b9;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_DATA:  rd_data = rx_byte_q;
            A_CTRL:  rd_data = DW'(ctrl_q);
            A_FLAGS: rd_data = DW'({rx_b9_q, rx_done_q, tx_done_q});
            default: rd_data = DW'(route_q);
        endcase
    end

    assign routed      = &route_q;
    assign serial_irq  = rx_done_q | (tx_done_q & ~routed);
    assign sysflag_irq = tx_done_q & routed;

    // R7: an overrun frame leaves the stored byte and flag untouched
    p_overrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_q && frame_pulse && !flag_wr) |=> ($stable(rx_byte_q) && rx_done_q));
    // R12: flags are sticky until a status write
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_q && !flag_wr) |=> tx_done_q);
    // R10: tx completion never raises both interrupt lines alone
    p_irq_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sysflag_irq && serial_irq && !rx_done_q));
endmodule

// File: tb/nine_bit_uart_bench.sv
module nine_bit_uart_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rxd = 1'b1;
    logic       t1_ovf = 1'b0;
    logic       t2_ovf = 1'b0;
    logic       txd, serial_irq, sysflag_irq;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    nine_bit_uart u_nine_bit_uart (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rxd(rxd), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf),
        .txd(txd), .serial_irq(serial_irq), .sysflag_irq(sysflag_irq)
    );

    initial begin
        for (int n = 0; ; n++) begin
            @(negedge clk);
            t1_ovf = (n % 3 == 0);
            t2_ovf = (n % 5 == 0);
        end
    end

    function automatic logic [7:0] mk_ctrl(bit en, bit b9, bit vm, int dv, bit ts, bit rs);
        return {1'b0, rs, ts, 2'(dv), vm, b9, en};
    endfunction

    function automatic int fixed_period(int dv);
        return (dv == 0) ? 16 : (dv == 1) ? 32 : 64;
    endfunction

    function automatic bit frame_bit(logic [7:0] d, bit b9, int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (i == 9) return b9;
        return 1'b1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Checks the frame appearing on txd; write is issued by the caller one negedge before
    task automatic check_tx(logic [7:0] d, bit b9, int p, string tag);
        int wait_n = 0;
        logic [7:0] st;
        while (txd !== 1'b0 && wait_n < 4 * p) begin
            @(negedge clk);
            wait_n++;
        end
        chk({tag, " R3 start latency"}, int'(wait_n <= p + 2), 1);
        repeat (p / 2) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            if (i > 0) repeat (p) @(negedge clk);
            chk({tag, " R1 frame bit"}, int'(txd), int'(frame_bit(d, b9, i)));
            if (i == 9) begin rd(2'd2, st); chk({tag, " R4 done low in bit9"}, int'(st[0]), 0); end
            if (i == 10) begin rd(2'd2, st); chk({tag, " R4 done at stop"}, int'(st[0]), 1); end
        end
        repeat (p) @(negedge clk);
    endtask

    task automatic tx_case(logic [7:0] ctrl, logic [7:0] d, int p, string tag);
        wr(2'd1, ctrl);
        wr(2'd2, 8'h00);
        wr(2'd0, d);
        check_tx(d, ctrl[1], p, tag);
    endtask

    task automatic send_rx(logic [7:0] d, bit b9, int p);
        for (int i = 0; i < 11; i++) begin
            rxd = frame_bit(d, b9, i);
            repeat (p) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_case(logic [7:0] ctrl, logic [7:0] d, bit b9, int p, string tag);
        logic [7:0] v;
        wr(2'd1, ctrl);
        wr(2'd2, 8'h00);
        send_rx(d, b9, p);
        rd(2'd2, v);
        chk({tag, " R6 rx_done"}, int'(v[1]), 1);
        chk({tag, " R6 rx bit9"}, int'(v[2]), int'(b9));
        rd(2'd0, v);
        chk({tag, " R6 rx byte"}, int'(v), int'(d));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        logic [7:0] v, d0;
        int unused_seed;
        unused_seed = $urandom(20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 txd idle", int'(txd), 1);
        chk("R11 serial_irq", int'(serial_irq), 0);
        chk("R11 sysflag_irq", int'(sysflag_irq), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R11 register zero", int'(v), 0);
        end

        // R8 fixed divisors, transmit and receive
        for (int dv = 0; dv < 4; dv++) begin
            logic [7:0] d = 8'($urandom);
            bit b = 1'($urandom);
            tx_case(mk_ctrl(1'b0, b, 1'b0, dv, 1'b0, 1'b0), d, fixed_period(dv), "R8 fixed tx");
            rx_case(mk_ctrl(1'b1, 1'b0, 1'b0, dv, 1'b0, 1'b0), ~d, ~b, fixed_period(dv), "R8 fixed rx");
        end

        // R10 interrupt routing with tx_done set, rx_done clear
        wr(2'd2, 8'h01);
        chk("R10 default serial", int'(serial_irq), 1);
        wr(2'd3, 8'h01);
        chk("R10 one bit serial", int'(serial_irq), 1);
        chk("R10 one bit sysflag", int'(sysflag_irq), 0);
        wr(2'd3, 8'h03);
        chk("R10 routed sysflag", int'(sysflag_irq), 1);
        chk("R10 routed serial", int'(serial_irq), 0);
        // R12 sticky then cleared by status write
        repeat (20) @(negedge clk);
        rd(2'd2, v);
        chk("R12 sticky tx_done", int'(v[0]), 1);
        wr(2'd2, 8'h00);
        rd(2'd2, v);
        chk("R12 cleared", int'(v[1:0]), 0);
        chk("R12 irq low", int'(sysflag_irq), 0);
        wr(2'd3, 8'h00);

        // R2 ninth bit captured at data write
        wr(2'd1, mk_ctrl(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0));
        wr(2'd0, 8'hA5);
        wr(2'd1, mk_ctrl(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0));
        check_tx(8'hA5, 1'b1, 16, "R2 ninth latched");

        // R3 write while pending ignored
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h3C);
        wr(2'd0, 8'hC3);
        check_tx(8'h3C, 1'b0, 16, "R3 busy");
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) break;
        end
        chk("R3 no second frame", int'(txd), 1);

        // R9 variable mode: tx on t1 (48 clocks), tx on t2 (80), rx on t2 with tx on t1
        tx_case(mk_ctrl(1'b0, 1'b1, 1'b1, 0, 1'b0, 1'b0), 8'($urandom), 48, "R9 var t1");
        tx_case(mk_ctrl(1'b0, 1'b0, 1'b1, 0, 1'b1, 1'b0), 8'($urandom), 80, "R9 var t2");
        rx_case(mk_ctrl(1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b1), 8'h96, 1'b1, 80, "R9 var rx t2");
        rx_case(mk_ctrl(1'b1, 1'b0, 1'b1, 0, 1'b1, 1'b0), 8'h5A, 1'b0, 48, "R9 var rx t1");

        // R7 overrun: second frame dropped while rx_done set
        rx_case(mk_ctrl(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0), 8'h81, 1'b1, 16, "R7 first");
        send_rx(8'h7E, 1'b0, 16);
        rd(2'd0, v);
        chk("R7 byte kept", int'(v), 'h81);
        rd(2'd2, v);
        chk("R7 bit9 kept", int'(v[2]), 1);

        // R5 receiver disabled ignores a frame
        wr(2'd1, mk_ctrl(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0));
        wr(2'd2, 8'h00);
        send_rx(8'h42, 1'b1, 16);
        rd(2'd2, v);
        chk("R5 disabled no flag", int'(v[1]), 0);
        rd(2'd0, v);
        chk("R5 disabled byte kept", int'(v), 'h81);

        // R5 false start: short low pulse is discarded, then a real frame is taken
        wr(2'd1, mk_ctrl(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0));
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        rd(2'd2, v);
        chk("R5 false start no flag", int'(v[1]), 0);
        rx_case(mk_ctrl(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0), 8'h24, 1'b0, 16, "R5 after false start");

        // Random mix
        for (int k = 0; k < 6; k++) begin
            int dv = int'($urandom % 3);
            d0 = 8'($urandom);
            tx_case(mk_ctrl(1'b0, 1'($urandom), 1'b0, dv, 1'b0, 1'b0), d0, fixed_period(dv), "R1 random tx");
            rx_case(mk_ctrl(1'b1, 1'b0, 1'b0, dv, 1'b0, 1'b0), d0 ^ 8'h5F, 1'($urandom), fixed_period(dv), "R6 random rx");
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end
endmodule